// File: doc/BRIEF.md
# Streaming 3x3 Image Convolver

This block filters a raster-scanned image stream with a programmable 3x3 kernel. It accepts one pixel per clock and produces one filtered result per clock in steady state. It needs no frame store outside itself. Two on-block row delays remember the two previous image lines, and a line-width setting fixes their length. Two column registers per row then complete the 3x3 neighbourhood around each incoming pixel.

Nine signed coefficient registers drive nine parallel multipliers. A full-width adder sums their products, and nothing is rounded or dropped anywhere on that path. A mode input bypasses the row delays. The block then multiplies nine samples supplied in parallel on a direct input by the nine coefficients. This serves as a general nine-term sum-of-products engine, for example when an outside controller sequences frame memory addresses.

Top module: `conv3x3_stream`

## Requirements
- R1: After reset `resValid` is 0, `resOut` is 0, all nine coefficients are 0 and the line width equals `MAX_LINE`.
- R2: A result equals the sum over k = 3*r + c of `coef[k] * tap[k]`, computed exactly in `ACC_W` = `PIX_W` + `COEF_W` + 5 bits. Pixels are unsigned and coefficients are two's complement. In window mode, row r = 0 is line y-2, r = 2 is the current line, c = 0 is column x-2, and k = 8 is the pixel just presented.
- R3: A pixel presented with `pixValid` in cycle n that yields a result puts it on `resOut` with `resValid` high in cycle n+3. Back-to-back pixels give back-to-back results without stalls.
- R4: In window mode the pixel presented with `sof` is column 0 of row 0. Columns count 0 to W-1, where W is the line width, and rows advance on wrap. A pixel yields a result only when its column is at least 2 and its row is at least 2.
- R5: With `bypass` high, every cycle with `pixValid` yields a result whose tap k is `tapIn[k*PIX_W +: PIX_W]`. The row delays and the column and row counts are left unchanged, so a window frame resumes where it paused.
- R6: `coefWe` with `coefAddr` 0 to 8 loads `coefData` into coefficient `coefAddr`. The new value applies to the pixel presented in the same cycle and to every later pixel. Addresses 9 to 15 change nothing.
- R7: `lwWe` loads the line width from `lwData` (legal values 3 to `MAX_LINE`) and clears the column and row counts. It acts only when the block is idle: no `pixValid` in that cycle, no result in flight and `resValid` low. Otherwise the write is ignored.
- R8: While `resValid` is low, `resOut` keeps the last result (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the presented pixel as first of a frame (window mode) |
| pixValid | input | 1 | A pixel (or a tap set in bypass) is presented this cycle |
| pixIn | input | PIX_W | Incoming raster pixel, unsigned |
| bypass | input | 1 | 1: use `tapIn` directly; 0: use the row-delay window |
| tapIn | input | 9*PIX_W | Nine direct samples for bypass mode, tap k in slice k |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 4 | Coefficient index |
| coefData | input | COEF_W | Signed coefficient value |
| lwWe | input | 1 | Line-width write strobe |
| lwData | input | $clog2(MAX_LINE+1) | New line width in pixels |
| resOut | output | PIX_W+COEF_W+5 | Signed full-precision result |
| resValid | output | 1 | `resOut` carries a new result this cycle |

## Verification
The critical coincidence is a coefficient write landing in the same cycle as a streaming pixel. Only the pixel of that cycle and later ones may see the new value. The result three cycles earlier and later must split exactly at that boundary. The bench provokes this by writing a coefficient mid-frame while `pixValid` stays high. It also aims a line-width write at a cycle where pixels are still flowing, and checks that later row wrapping still follows the old width. A cycle-level reference model recomputes every expected window and result from its own pixel history and compares `resValid` and `resOut` on each clock.

// File: rtl/conv_pkg.sv
package conv_pkg;
  // Kernel geometry is fixed at 3x3; widths stay parameters on the modules.
  localparam int KDIM = 3;
  localparam int TAPS = KDIM * KDIM;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic accept;    // window-mode pixel taken: write row delays, shift columns
    logic winValid;  // the taps of this cycle form a result worth computing
    logic useTaps;   // take the nine taps from the direct input
  } ctrl_strobe_t;
endpackage

// File: rtl/conv_rowdelay.sv
// One raster-line delay: a memory addressed by the current column.
// Reading the old value and writing the new one share the same address,
// so the output is the pixel from the same column one line earlier.
module conv_rowdelay #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] ptr,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] dout
);
  logic [PIX_W-1:0] mem [DEPTH];

  assign dout = mem[ptr];

  always_ff @(posedge clk) begin
    if (we) mem[ptr] <= din;
  end
endmodule

// File: rtl/conv_ctrl.sv
// Control: line-width register, column/row position, idle detection and
// the per-cycle strobes to the datapath.
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int MAX_LINE = 1024,
  parameter int PTR_W    = $clog2(MAX_LINE),
  parameter int LW_W     = $clog2(MAX_LINE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sof,
  input  logic             pixValid,
  input  logic             bypass,
  input  logic             lwWe,
  input  logic [LW_W-1:0]  lwData,
  input  logic             pipeBusy,
  output logic [PTR_W-1:0] ptr,
  output ctrl_strobe_t     strobe
);
  localparam logic [1:0] LAST_ROW = 2'(KDIM - 1);

  logic [LW_W-1:0]  lineWidth;
  logic [PTR_W-1:0] colCnt;
  logic [1:0]       rowCnt;
  logic [PTR_W-1:0] curCol;
  logic [1:0]       curRow;
  logic             idle;
  logic             lwLoad;
  logic             lastCol;
  logic             fullWin;

  always_comb begin
    curCol  = sof ? '0 : colCnt;
    curRow  = sof ? '0 : rowCnt;
    idle    = !pixValid && !pipeBusy;
    lwLoad  = lwWe && idle;
    lastCol = (LW_W'(curCol) == (lineWidth - LW_W'(1)));
    fullWin = (curCol >= PTR_W'(KDIM - 1)) && (curRow == LAST_ROW);
  end

  always_comb begin
    strobe.accept   = pixValid && !bypass;
    strobe.useTaps  = bypass;
    strobe.winValid = pixValid && (bypass || fullWin);
    ptr             = curCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineWidth <= LW_W'(MAX_LINE);
      colCnt    <= '0;
      rowCnt    <= '0;
    end else if (lwLoad) begin
      lineWidth <= lwData;
      colCnt    <= '0;
      rowCnt    <= '0;
    end else if (strobe.accept) begin
      colCnt <= lastCol ? '0 : curCol + PTR_W'(1);
      if (lastCol && (curRow != LAST_ROW)) rowCnt <= curRow + 2'd1;
      else                                 rowCnt <= curRow;
    end
  end
endmodule

// File: rtl/conv_datapath.sv
// Datapath: coefficient bank, two chained row delays, column history,
// tap selection and the three-stage multiply-add pipeline.
module conv_datapath
  import conv_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 12,
  parameter int MAX_LINE = 1024,
  parameter int PTR_W    = $clog2(MAX_LINE),
  parameter int ACC_W    = PIX_W + COEF_W + 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobe_t             strobe,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [PIX_W-1:0]         pixIn,
  input  logic [TAPS*PIX_W-1:0]    tapIn,
  input  logic                     coefWe,
  input  logic [3:0]               coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic signed [ACC_W-1:0]  resOut,
  output logic                     resValid,
  output logic                     pipeBusy
);
  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam int NLINES = KDIM - 1;

  logic signed [COEF_W-1:0] coefReg [TAPS];
  logic [PIX_W-1:0]         lineOut [NLINES];
  logic [PIX_W-1:0]         colNow  [KDIM];
  logic [PIX_W-1:0]         colPrev1[KDIM];
  logic [PIX_W-1:0]         colPrev2[KDIM];
  logic [PIX_W-1:0]         winTap  [TAPS];
  logic [PIX_W-1:0]         winReg  [TAPS];
  logic signed [PROD_W-1:0] prodNext[TAPS];
  logic signed [PROD_W-1:0] prodReg [TAPS];
  logic signed [ACC_W-1:0]  sumNext;
  logic                     v1;
  logic                     v2;

  // Coefficient bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) coefReg[k] <= '0;
    end else if (coefWe) begin
      for (int k = 0; k < TAPS; k++)
        if (coefAddr == 4'(k)) coefReg[k] <= coefData;
    end
  end

  // Row delays: line 0 holds row y-1, line 1 holds row y-2
  for (genvar g = 0; g < NLINES; g++) begin : gLine
    logic [PIX_W-1:0] lineIn;
    if (g == 0) begin : gFirst
      assign lineIn = pixIn;
    end else begin : gChain
      assign lineIn = lineOut[g-1];
    end
    conv_rowdelay #(
      .PIX_W(PIX_W),
      .DEPTH(MAX_LINE),
      .PTR_W(PTR_W)
    ) uLine (
      .clk (clk),
      .we  (strobe.accept),
      .ptr (ptr),
      .din (lineIn),
      .dout(lineOut[g])
    );
  end

  // Current column, oldest row first
  always_comb begin
    colNow[KDIM-1] = pixIn;
    for (int r = 0; r < KDIM - 1; r++) colNow[r] = lineOut[KDIM-2-r];
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      colPrev1 <= colNow;
      colPrev2 <= colPrev1;
    end
  end

  // Tap selection: window or direct samples
  always_comb begin
    for (int r = 0; r < KDIM; r++) begin
      for (int c = 0; c < KDIM; c++) begin
        if (strobe.useTaps)
          winTap[r*KDIM+c] = tapIn[(r*KDIM+c)*PIX_W +: PIX_W];
        else if (c == KDIM - 1)
          winTap[r*KDIM+c] = colNow[r];
        else if (c == KDIM - 2)
          winTap[r*KDIM+c] = colPrev1[r];
        else
          winTap[r*KDIM+c] = colPrev2[r];
      end
    end
  end

  // Stage 1: capture taps
  always_ff @(posedge clk) begin
    if (!rstN) v1 <= 1'b0;
    else       v1 <= strobe.winValid;
    winReg <= winTap;
  end

  // Stage 2: nine exact products
  for (genvar k = 0; k < TAPS; k++) begin : gLane
    logic signed [PROD_W-1:0] pixS;
    logic signed [PROD_W-1:0] coefS;
    always_comb begin
      pixS        = {{(PROD_W-PIX_W){1'b0}}, winReg[k]};
      coefS       = {{(PROD_W-COEF_W){coefReg[k][COEF_W-1]}}, coefReg[k]};
      prodNext[k] = pixS * coefS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) v2 <= 1'b0;
    else       v2 <= v1;
    prodReg <= prodNext;
  end

  // Stage 3: full-width sum
  always_comb begin
    sumNext = '0;
    for (int k = 0; k < TAPS; k++)
      sumNext = sumNext + {{(ACC_W-PROD_W){prodReg[k][PROD_W-1]}}, prodReg[k]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resOut   <= '0;
    end else begin
      resValid <= v2;
      if (v2) resOut <= sumNext;
    end
  end

  assign pipeBusy = v1 || v2 || resValid;
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 12,
  parameter int MAX_LINE = 1024
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               sof,
  input  logic                               pixValid,
  input  logic [PIX_W-1:0]                   pixIn,
  input  logic                               bypass,
  input  logic [9*PIX_W-1:0]                 tapIn,
  input  logic                               coefWe,
  input  logic [3:0]                         coefAddr,
  input  logic signed [COEF_W-1:0]           coefData,
  input  logic                               lwWe,
  input  logic [$clog2(MAX_LINE+1)-1:0]      lwData,
  output logic signed [PIX_W+COEF_W+4:0]     resOut,
  output logic                               resValid
);
  localparam int PTR_W = $clog2(MAX_LINE);
  localparam int LW_W  = $clog2(MAX_LINE + 1);
  localparam int ACC_W = PIX_W + COEF_W + 5;

  ctrl_strobe_t     strobe;
  logic [PTR_W-1:0] ptr;
  logic             pipeBusy;

  conv_ctrl #(
    .MAX_LINE(MAX_LINE),
    .PTR_W   (PTR_W),
    .LW_W    (LW_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sof     (sof),
    .pixValid(pixValid),
    .bypass  (bypass),
    .lwWe    (lwWe),
    .lwData  (lwData),
    .pipeBusy(pipeBusy),
    .ptr     (ptr),
    .strobe  (strobe)
  );

  conv_datapath #(
    .PIX_W   (PIX_W),
    .COEF_W  (COEF_W),
    .MAX_LINE(MAX_LINE),
    .PTR_W   (PTR_W),
    .ACC_W   (ACC_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ptr     (ptr),
    .pixIn   (pixIn),
    .tapIn   (tapIn),
    .coefWe  (coefWe),
    .coefAddr(coefAddr),
    .coefData(coefData),
    .resOut  (resOut),
    .resValid(resValid),
    .pipeBusy(pipeBusy)
  );
endmodule

// File: rtl/conv3x3_checker.sv
module conv3x3_checker #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           sof,
  input logic                           pixValid,
  input logic                           bypass,
  input logic                           resValid,
  input logic [PIX_W+COEF_W+4:0]        resOut
);
  // R3: a result never appears without a pixel three cycles earlier
  a_r3_result_has_source: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(pixValid, 3));

  // R5: every bypass sample produces a result three cycles later
  a_r5_bypass_always_yields: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pixValid, 3) && $past(bypass, 3)) |-> resValid);

  // R4: the first pixel of a frame never produces a result
  a_r4_frame_start_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(pixValid && sof && !bypass, 3) |-> !resValid);

  // R8: the output holds while no result is flagged
  a_r8_output_holds: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(resOut));
endmodule

bind conv3x3_stream conv3x3_checker #(
  .PIX_W (PIX_W),
  .COEF_W(COEF_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .sof     (sof),
  .pixValid(pixValid),
  .bypass  (bypass),
  .resValid(resValid),
  .resOut  (resOut)
);

// File: tb/tb_conv3x3_stream.sv
module tb_conv3x3_stream;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 12;
  localparam int MAX_LINE = 1024;
  localparam int LW_W     = $clog2(MAX_LINE + 1);
  localparam int ACC_W    = PIX_W + COEF_W + 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sof = 1'b0;
  logic pixValid = 1'b0;
  logic [PIX_W-1:0] pixIn = '0;
  logic bypass = 1'b0;
  logic [9*PIX_W-1:0] tapIn = '0;
  logic coefWe = 1'b0;
  logic [3:0] coefAddr = '0;
  logic signed [COEF_W-1:0] coefData = '0;
  logic lwWe = 1'b0;
  logic [LW_W-1:0] lwData = '0;
  logic signed [ACC_W-1:0] resOut;
  logic resValid;

  always #5 clk = ~clk;

  conv3x3_stream #(.PIX_W(PIX_W), .COEF_W(COEF_W), .MAX_LINE(MAX_LINE)) dut (
    .clk(clk), .rstN(rstN), .sof(sof), .pixValid(pixValid), .pixIn(pixIn),
    .bypass(bypass), .tapIn(tapIn), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .lwWe(lwWe), .lwData(lwData),
    .resOut(resOut), .resValid(resValid));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string phase = "R1";

  // Reference model state
  longint mCoef[9];
  int     mWidth = MAX_LINE;
  int     frm[$];
  bit     expV[int];
  longint expD[int];
  longint lastOut = 0;

  function automatic bit vAt(int c);
    return expV.exists(c);
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", phase, what, cyc, act, exp);
    end
  endtask

  task automatic checkOutputs();
    bit ev;
    ev = vAt(cyc);
    check(resValid === ev, "resValid", longint'(resValid), longint'(ev));
    if (ev) begin
      check(longint'(resOut) == expD[cyc], "resOut", longint'(resOut), expD[cyc]);
      lastOut = expD[cyc];
    end else begin
      check(longint'(resOut) == lastOut, "resOut held (R8)", longint'(resOut), lastOut);
    end
  endtask

  // Model the inputs of the current cycle, advance one clock, check.
  task automatic tick();
    bit idle;
    longint s;
    int p, x, y;
    idle = !pixValid && !vAt(cyc) && !vAt(cyc + 1) && !vAt(cyc + 2);
    if (coefWe && coefAddr < 4'd9) mCoef[coefAddr] = longint'(coefData);
    if (lwWe && idle) begin
      mWidth = int'(lwData);
      frm.delete();
    end
    if (pixValid) begin
      if (bypass) begin
        s = 0;
        for (int k = 0; k < 9; k++)
          s += longint'(tapIn[k*PIX_W +: PIX_W]) * mCoef[k];
        expV[cyc + 3] = 1'b1;
        expD[cyc + 3] = s;
      end else begin
        if (sof) frm.delete();
        p = frm.size();
        frm.push_back(int'(pixIn));
        x = p % mWidth;
        y = p / mWidth;
        if (x >= 2 && y >= 2) begin
          s = 0;
          for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
              s += longint'(frm[p - (2 - r) * mWidth - (2 - c)]) * mCoef[r*3 + c];
          expV[cyc + 3] = 1'b1;
          expD[cyc + 3] = s;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    checkOutputs();
  endtask

  task automatic quiet(int n);
    sof = 0; pixValid = 0; coefWe = 0; lwWe = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic writeCoef(int addr, int val);
    coefWe = 1; coefAddr = 4'(addr); coefData = COEF_W'(val);
    tick();
    coefWe = 0;
  endtask

  task automatic writeWidth(int w);
    lwWe = 1; lwData = LW_W'(w);
    tick();
    lwWe = 0;
  endtask

  task automatic sendPix(int v, bit first);
    bypass = 0; pixValid = 1; sof = first; pixIn = PIX_W'(v);
    tick();
    pixValid = 0; sof = 0;
  endtask

  task automatic sendTaps(int seed);
    bypass = 1; pixValid = 1;
    for (int k = 0; k < 9; k++) tapIn[k*PIX_W +: PIX_W] = PIX_W'((seed * 29 + k * 53 + 7) % 256);
    tick();
    pixValid = 0; bypass = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-R8 run: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 9; k++) mCoef[k] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state
    phase = "R1";
    checkOutputs();
    quiet(2);

    // R1 + R5: coefficients are zero out of reset
    phase = "R1 R5 zero coefficients";
    for (int i = 0; i < 3; i++) sendTaps(i + 1);
    quiet(4);

    // R6: load an asymmetric kernel, then an out-of-range address
    phase = "R6 coefficient load";
    writeCoef(0, -2048); writeCoef(1, 2047); writeCoef(2, 5);
    writeCoef(3, -7);    writeCoef(4, 100);  writeCoef(5, -1);
    writeCoef(6, 0);     writeCoef(7, 33);   writeCoef(8, -300);
    writeCoef(12, 999);
    writeCoef(9, -555);
    quiet(1);

    // R2 + R5: bypass extremes and back-to-back samples
    phase = "R2 R5 bypass";
    bypass = 1; pixValid = 1; tapIn = '1;
    tick();
    tapIn = '0; tapIn[7:0] = 8'hFF;
    tick();
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 9; k++) tapIn[k*PIX_W +: PIX_W] = PIX_W'((i * 71 + k * 13 + 3) % 256);
      tick();
    end
    pixValid = 0; bypass = 0;
    quiet(4);

    // R7: accepted width write while idle
    phase = "R7 width write idle";
    writeWidth(5);
    quiet(1);

    // R2 R3 R4 R6 R7: 5-wide frame with gaps, same-cycle coefficient write,
    // and a width write that collides with a pixel
    phase = "R2 R3 R4 frame 5 wide";
    for (int i = 0; i < 25; i++) begin
      bypass = 0; pixValid = 1; sof = (i == 0); pixIn = PIX_W'((i * 37 + 11) % 256);
      if (i == 7) begin lwWe = 1; lwData = LW_W'(3); phase = "R7 width write busy"; end
      if (i == 13) begin coefWe = 1; coefAddr = 4'd4; coefData = COEF_W'(-900); phase = "R6 same-cycle write"; end
      tick();
      lwWe = 0; coefWe = 0; pixValid = 0; sof = 0;
      phase = "R2 R3 R4 frame 5 wide";
      if (i % 6 == 5) quiet(2);
    end
    // R7: write right after the stream, while results are still in flight
    phase = "R7 width write in flight";
    writeWidth(4);
    quiet(4);

    // R4 R5: frame restarted by sof, bypass pause, resume without sof
    phase = "R4 R5 frame pause";
    for (int i = 0; i < 7; i++) sendPix((i * 19 + 200) % 256, i == 0);
    sendTaps(9); sendTaps(10); sendTaps(11);
    for (int i = 0; i < 16; i++) begin
      bypass = 0; pixValid = 1; sof = 0; pixIn = PIX_W'((i * 91 + 5) % 256);
      tick();
    end
    pixValid = 0;
    // R4: sof mid-row restarts counting
    phase = "R4 restart mid-row";
    for (int i = 0; i < 14; i++) begin
      bypass = 0; pixValid = 1; sof = (i == 0); pixIn = PIX_W'((i * 43 + 1) % 256);
      tick();
    end
    quiet(5);

    // R3 R7: narrowest width, back-to-back
    phase = "R3 R7 width 3";
    writeWidth(3);
    for (int i = 0; i < 12; i++) begin
      bypass = 0; pixValid = 1; sof = (i == 0); pixIn = PIX_W'(255 - i * 17);
      tick();
    end
    quiet(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule